// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register File

This block holds three free-running counters and the registers that govern them: a 40-bit real-time counter in 1/256-second units, a 40-bit interval timer and a 32-bit cycle counter. Each counter has an alarm register, and a status and a control byte complete a 30-byte window. The window starts at a base address, 200h by default. A 256 Hz tick advances the real-time counter. The same tick advances the interval timer while its run bit is set, and a power-cycle pulse advances the cycle counter. Nothing counts unless the oscillator-enable bit is set.

Counter values are never read live. A snapshot strobe, issued when a read command has been fully received, copies every counter into holding registers in one cycle. All later byte reads come from that copy, so a multi-byte value read over several accesses is always consistent. When a counter steps onto its alarm value, a sticky flag is raised. An interrupt output is raised when a flag is set and its enable bit is also set.

Top module: `tkeep_regs`

## Requirements
- R1: After reset, every counter, holding register, alarm register, the status byte and the control byte are zero, and `alarmIrq` is low.
- R2: Offsets from the base address are as follows: status at 0, control at 1, real-time counter at 2..6, interval timer at 7..11, cycle counter at 12..15, real-time alarm at 16..20, interval alarm at 21..25 and cycle alarm at 26..29. Multi-byte values are little-endian. Status and control read their live values. A read outside the window returns 00h.
- R3: While control bit 0 (oscillator enable) is set, each `tick` pulse adds one to the 40-bit real-time counter. Byte 0 holds the 1/256-second fraction, and carries ripple into the upper four bytes.
- R4: While control bit 0 is clear, `tick` and `powerCycle` change no counter.
- R5: A counter byte read returns the value captured at the most recent `snapStrobe`. Counting after the strobe does not alter the value read until the next strobe.
- R6: The interval timer advances on `tick` only when control bit 0 and control bit 1 (run) are both set.
- R7: The cycle counter advances by one on each `powerCycle` pulse while control bit 0 is set.
- R8: When an increment makes a counter equal to its alarm value, that counter's flag is set in the status byte: bit 0 for the real-time counter, bit 1 for the interval timer and bit 2 for the cycle counter. The flag stays set until the status byte is read. The read itself still shows the flag, and the flag is clear from the next cycle on.
- R9: `alarmIrq` is high exactly when some flag is set and its enable bit is set. Status bits 3, 4 and 5 enable the real-time, interval and cycle alarms.
- R10: Control bits 4, 5 and 6 write-protect the real-time, interval and cycle counters respectively. A write to a protected counter is ignored. Alarm registers remain writable.
- R11: The real-time counter wraps from all ones to zero.
- R12: A status write changes only the enable bits 3..5. Writes to the flag bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 256 Hz |
| powerCycle | input | 1 | One-cycle pulse per system power cycle |
| snapStrobe | input | 1 | Copies all counters to the holding registers |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; a read of the status byte clears the flags |
| rdData | output | 8 | Combinational read data for `addr` |
| alarmIrq | output | 1 | Alarm interrupt |

## Verification
The hardest state to reach is an alarm match at a precise count. The counter must first be preloaded byte by byte and the alarm registers written. The stimulus then ticks the counter one step at a time, so the flag is seen to rise on exactly the matching step and not on the step before it. A second hard state is the carry out of the all-ones value. It is reached by preloading FFh into all five bytes and issuing a single tick. After the preload, the bench drives the block only through snapshot reads and never reads counters live. Each expected value is therefore derived from the tick count since the last preload.

// File: rtl/tkeep_pkg.sv
package tkeep_pkg;
  localparam int NUM_CTR = 3;
  localparam int CTR_RTC = 0;
  localparam int CTR_ITV = 1;
  localparam int CTR_CYC = 2;

  localparam int RTC_B = 5;
  localparam int ITV_B = 5;
  localparam int CYC_B = 4;
  localparam int MAX_B = 5;

  localparam int OFF_W = 5;
  localparam int OFF_STATUS = 0;
  localparam int OFF_CONTROL = 1;
  localparam int OFF_CTR_BASE = 2;
  localparam int OFF_ALM_BASE = 16;
  localparam int MAP_SIZE = OFF_ALM_BASE + RTC_B + ITV_B + CYC_B;

  // control byte bits
  localparam int CB_OSC = 0;
  localparam int CB_RUN = 1;
  localparam int CB_AUTO = 2;
  localparam int CB_DSEL = 3;
  localparam int CB_WP0 = 4;
  localparam int CB_RO = 7;

  // status byte bits
  localparam int SB_FLAG0 = 0;
  localparam int SB_EN0 = 3;

  function automatic int ctrBytes(input int g);
    case (g)
      CTR_RTC: return RTC_B;
      CTR_ITV: return ITV_B;
      default: return CYC_B;
    endcase
  endfunction

  function automatic int prevBytes(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += ctrBytes(i);
    return acc;
  endfunction

  function automatic int ctrOff(input int g);
    return OFF_CTR_BASE + prevBytes(g);
  endfunction

  function automatic int almOff(input int g);
    return OFF_ALM_BASE + prevBytes(g);
  endfunction

  typedef struct packed {
    logic [NUM_CTR-1:0] cntWr;
    logic [NUM_CTR-1:0] almWr;
    logic [2:0]         byteIdx;
    logic [NUM_CTR-1:0] inc;
    logic               snap;
  } tkStrobe_t;
endpackage

// File: rtl/tkeep_ctr.sv
module tkeep_ctr #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inc,
  input  logic          snap,
  input  logic          cntWr,
  input  logic          almWr,
  input  logic [2:0]    byteIdx,
  input  logic [7:0]    wrData,
  output logic [8*NB-1:0] live,
  output logic [8*NB-1:0] hold,
  output logic [8*NB-1:0] alarm,
  output logic          hit
);
  localparam int W = 8 * NB;

  logic [W-1:0] nextVal;
  assign nextVal = live + W'(1);

  // a byte write takes the cycle; the increment is skipped then
  assign hit = inc && !cntWr && (nextVal == alarm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live <= '0;
    end else if (cntWr) begin
      for (int b = 0; b < NB; b++)
        if (byteIdx == 3'(b)) live[8*b +: 8] <= wrData;
    end else if (inc) begin
      live <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarm <= '0;
    end else if (almWr) begin
      for (int b = 0; b < NB; b++)
        if (byteIdx == 3'(b)) alarm[8*b +: 8] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hold <= '0;
    else if (snap) hold <= live;
  end
endmodule

// File: rtl/tkeep_ctrl.sv
module tkeep_ctrl
  import tkeep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               powerCycle,
  input  logic               snapStrobe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [7:0]         wrData,
  input  logic               rdEn,
  input  logic [NUM_CTR-1:0] hit,
  output tkStrobe_t          st,
  output logic               inRange,
  output logic [OFF_W-1:0]   regOff,
  output logic [7:0]         statusByte,
  output logic [7:0]         ctrlReg,
  output logic [NUM_CTR-1:0] flagVec,
  output logic [NUM_CTR-1:0] enVec,
  output logic               alarmIrq
);
  logic [ADDR_W-1:0] rel;
  logic wrStatus, wrControl, clrFlags;

  assign rel     = addr - ADDR_W'(BASE);
  assign inRange = (addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(MAP_SIZE));
  assign regOff  = rel[OFF_W-1:0];

  assign wrStatus  = wrEn && inRange && (regOff == OFF_W'(OFF_STATUS));
  assign wrControl = wrEn && inRange && (regOff == OFF_W'(OFF_CONTROL));
  assign clrFlags  = rdEn && inRange && (regOff == OFF_W'(OFF_STATUS));

  always_comb begin
    st = '0;
    for (int g = 0; g < NUM_CTR; g++) begin
      if (inRange && int'(regOff) >= ctrOff(g) && int'(regOff) < ctrOff(g) + ctrBytes(g)) begin
        st.cntWr[g] = wrEn && !ctrlReg[CB_WP0+g];
        st.byteIdx  = 3'(int'(regOff) - ctrOff(g));
      end
      if (inRange && int'(regOff) >= almOff(g) && int'(regOff) < almOff(g) + ctrBytes(g)) begin
        st.almWr[g] = wrEn;
        st.byteIdx  = 3'(int'(regOff) - almOff(g));
      end
    end
    st.inc[CTR_RTC] = tick && ctrlReg[CB_OSC];
    st.inc[CTR_ITV] = tick && ctrlReg[CB_OSC] && ctrlReg[CB_RUN];
    st.inc[CTR_CYC] = powerCycle && ctrlReg[CB_OSC];
    st.snap         = snapStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      enVec   <= '0;
      flagVec <= '0;
    end else begin
      if (wrControl) ctrlReg <= wrData;
      if (wrStatus)  enVec   <= wrData[SB_EN0 +: NUM_CTR];
      flagVec <= (clrFlags ? '0 : flagVec) | hit;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[SB_FLAG0 +: NUM_CTR] = flagVec;
    statusByte[SB_EN0 +: NUM_CTR]   = enVec;
  end

  assign alarmIrq = |(flagVec & enVec);
endmodule

// File: rtl/tkeep_dp.sv
module tkeep_dp
  import tkeep_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  tkStrobe_t                         st,
  input  logic [7:0]                        wrData,
  input  logic                              inRange,
  input  logic [OFF_W-1:0]                  regOff,
  input  logic [7:0]                        statusByte,
  input  logic [7:0]                        ctrlReg,
  output logic [NUM_CTR-1:0]                hit,
  output logic [NUM_CTR-1:0][8*MAX_B-1:0]   liveArr,
  output logic [7:0]                        rdData
);
  logic [NUM_CTR-1:0][8*MAX_B-1:0] holdArr;
  logic [NUM_CTR-1:0][8*MAX_B-1:0] almArr;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam int NB = ctrBytes(g);
    tkeep_ctr #(.NB(NB)) u_ctr (
      .clk     (clk),
      .rstN    (rstN),
      .inc     (st.inc[g]),
      .snap    (st.snap),
      .cntWr   (st.cntWr[g]),
      .almWr   (st.almWr[g]),
      .byteIdx (st.byteIdx),
      .wrData  (wrData),
      .live    (liveArr[g][8*NB-1:0]),
      .hold    (holdArr[g][8*NB-1:0]),
      .alarm   (almArr[g][8*NB-1:0]),
      .hit     (hit[g])
    );
    if (NB < MAX_B) begin : g_pad
      assign liveArr[g][8*MAX_B-1:8*NB] = '0;
      assign holdArr[g][8*MAX_B-1:8*NB] = '0;
      assign almArr[g][8*MAX_B-1:8*NB]  = '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (inRange) begin
      if (regOff == OFF_W'(OFF_STATUS))  rdData = statusByte;
      if (regOff == OFF_W'(OFF_CONTROL)) rdData = ctrlReg;
      for (int g = 0; g < NUM_CTR; g++) begin
        if (int'(regOff) >= ctrOff(g) && int'(regOff) < ctrOff(g) + ctrBytes(g))
          rdData = holdArr[g][8*(int'(regOff) - ctrOff(g)) +: 8];
        if (int'(regOff) >= almOff(g) && int'(regOff) < almOff(g) + ctrBytes(g))
          rdData = almArr[g][8*(int'(regOff) - almOff(g)) +: 8];
      end
    end
  end
endmodule

// File: rtl/tkeep_regs.sv
module tkeep_regs
  import tkeep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              powerCycle,
  input  logic              snapStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              alarmIrq
);
  tkStrobe_t                       st;
  logic                            inRange;
  logic [OFF_W-1:0]                regOff;
  logic [7:0]                      statusByte;
  logic [7:0]                      ctrlReg;
  logic [NUM_CTR-1:0]              flagVec;
  logic [NUM_CTR-1:0]              enVec;
  logic [NUM_CTR-1:0]              hit;
  logic [NUM_CTR-1:0][8*MAX_B-1:0] liveArr;

  tkeep_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .powerCycle (powerCycle),
    .snapStrobe (snapStrobe),
    .addr       (addr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .hit        (hit),
    .st         (st),
    .inRange    (inRange),
    .regOff     (regOff),
    .statusByte (statusByte),
    .ctrlReg    (ctrlReg),
    .flagVec    (flagVec),
    .enVec      (enVec),
    .alarmIrq   (alarmIrq)
  );

  tkeep_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .wrData     (wrData),
    .inRange    (inRange),
    .regOff     (regOff),
    .statusByte (statusByte),
    .ctrlReg    (ctrlReg),
    .hit        (hit),
    .liveArr    (liveArr),
    .rdData     (rdData)
  );
endmodule

// File: rtl/tkeep_regs_chk.sv
module tkeep_regs_chk
  import tkeep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h200
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            tick,
  input logic                            powerCycle,
  input logic                            wrEn,
  input logic                            rdEn,
  input logic [ADDR_W-1:0]               addr,
  input logic [NUM_CTR-1:0][8*MAX_B-1:0] liveArr,
  input logic [NUM_CTR-1:0]              flagVec,
  input logic [NUM_CTR-1:0]              enVec,
  input logic [7:0]                      ctrlReg,
  input logic                            alarmIrq
);
  localparam int RW = 8 * RTC_B;

  function automatic logic hitsRange(input logic [ADDR_W-1:0] a, input int off, input int n);
    return (int'(a) >= BASE + off) && (int'(a) < BASE + off + n);
  endfunction

  logic wrRtc, wrItv, wrCyc, rdStatus, wrStatusChk;
  assign wrRtc       = wrEn && hitsRange(addr, ctrOff(CTR_RTC), RTC_B);
  assign wrItv       = wrEn && hitsRange(addr, ctrOff(CTR_ITV), ITV_B);
  assign wrCyc       = wrEn && hitsRange(addr, ctrOff(CTR_CYC), CYC_B);
  assign rdStatus    = rdEn && (int'(addr) == BASE + OFF_STATUS);
  assign wrStatusChk = wrEn && (int'(addr) == BASE + OFF_STATUS);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (liveArr == '0 && flagVec == '0 && !alarmIrq));

  // R3
  p_rtc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ctrlReg[CB_OSC] && !wrRtc) |=>
      liveArr[CTR_RTC][RW-1:0] == RW'($past(liveArr[CTR_RTC][RW-1:0]) + RW'(1)));

  // R11
  p_rtc_wrap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tick && ctrlReg[CB_OSC] && !wrRtc && (&liveArr[CTR_RTC][RW-1:0])) |=>
      liveArr[CTR_RTC][RW-1:0] == '0);

  // R4
  p_osc_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[CB_OSC] && !wrRtc && !wrItv && !wrCyc) |=>
      ($stable(liveArr[CTR_RTC]) && $stable(liveArr[CTR_ITV]) && $stable(liveArr[CTR_CYC])));

  // R7
  p_cyc_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!powerCycle && !wrCyc) |=> $stable(liveArr[CTR_CYC]));

  // R8
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  // R10
  p_wp_rtc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrRtc && ctrlReg[CB_WP0+CTR_RTC] && !(tick && ctrlReg[CB_OSC])) |=>
      $stable(liveArr[CTR_RTC]));

  // R12
  p_en_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wrStatusChk |=> $stable(enVec));
endmodule

bind tkeep_regs tkeep_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (.*);

// File: tb/tkeep_regs_tb.sv
module tkeep_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SNAP = 2'd2, K_TICK = 2'd3;

  typedef struct packed {
    logic [1:0] kind;
    logic [9:0] adr;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{K_WR,   10'h201, 8'h03, 4'd6},  // R6 osc + run
    '{K_WR,   10'h202, 8'hFE, 4'd3},  // R3 preload fraction byte
    '{K_WR,   10'h207, 8'h10, 4'd6},  // R6 preload interval
    '{K_TICK, 10'h000, 8'h03, 4'd3},
    '{K_RD,   10'h202, 8'h00, 4'd5},  // R5 no snapshot yet
    '{K_SNAP, 10'h000, 8'h00, 4'd5},
    '{K_RD,   10'h202, 8'h01, 4'd3},  // R3 carry out of fraction
    '{K_RD,   10'h203, 8'h01, 4'd3},
    '{K_RD,   10'h204, 8'h00, 4'd3},
    '{K_RD,   10'h207, 8'h13, 4'd6},
    '{K_RD,   10'h201, 8'h03, 4'd2},  // R2 control live
    '{K_RD,   10'h21E, 8'h00, 4'd2},  // R2 above window
    '{K_RD,   10'h1FF, 8'h00, 4'd2},  // R2 below window
    '{K_TICK, 10'h000, 8'h02, 4'd3},
    '{K_RD,   10'h202, 8'h01, 4'd5},  // R5 held value
    '{K_SNAP, 10'h000, 8'h00, 4'd5},
    '{K_RD,   10'h202, 8'h03, 4'd5},
    '{K_RD,   10'h203, 8'h01, 4'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, powerCycle = 1'b0, snapStrobe = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic alarmIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tkeep_regs #(.ADDR_W(ADDR_W), .BASE('h200)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .powerCycle(powerCycle),
    .snapStrobe(snapStrobe), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .alarmIrq(alarmIrq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 check(tag, rdData, exp);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); powerCycle = 1'b1;
      @(negedge clk); powerCycle = 1'b0;
    end
  endtask

  task automatic snap();
    @(negedge clk); snapStrobe = 1'b1;
    @(negedge clk); snapStrobe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdCheck(10'h200, 8'h00, "R1 status");
    rdCheck(10'h201, 8'h00, "R1 control");
    snap();
    rdCheck(10'h202, 8'h00, "R1 rtc");
    check("R1 irq", {7'b0, alarmIrq}, 8'h00);

    // table walk: R2 R3 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      case (VECS[v].kind)
        K_WR:   wrReg(VECS[v].adr, VECS[v].data);
        K_SNAP: snap();
        K_TICK: ticks(int'(VECS[v].data));
        default: rdCheck(VECS[v].adr, VECS[v].data, $sformatf("R%0d vec %0d", VECS[v].req, v));
      endcase
    end

    // R8 / R9 alarm on the real-time counter (live value 0x103)
    wrReg(10'h210, 8'h05);
    wrReg(10'h211, 8'h01);
    wrReg(10'h200, 8'h08);
    check("R9 irq idle", {7'b0, alarmIrq}, 8'h00);
    ticks(1);
    check("R8 no flag before match", {7'b0, alarmIrq}, 8'h00);
    ticks(1);
    check("R9 irq on match", {7'b0, alarmIrq}, 8'h01);
    rdCheck(10'h200, 8'h09, "R8 flag shown");
    rdCheck(10'h200, 8'h08, "R8 flag cleared by read");
    check("R9 irq after clear", {7'b0, alarmIrq}, 8'h00);

    // R11 wrap
    for (int b = 0; b < 5; b++) wrReg(ADDR_W'(10'h202 + b), 8'hFF);
    ticks(1);
    snap();
    for (int b = 0; b < 5; b++) rdCheck(ADDR_W'(10'h202 + b), 8'h00, "R11 wrap");

    // R4 oscillator off
    wrReg(10'h201, 8'h00);
    ticks(4);
    pulses(1);
    snap();
    rdCheck(10'h202, 8'h00, "R4 rtc frozen");
    rdCheck(10'h207, 8'h18, "R4 interval frozen");
    rdCheck(10'h20C, 8'h00, "R4 cycle frozen");

    // R6 run bit clear
    wrReg(10'h201, 8'h01);
    ticks(2);
    snap();
    rdCheck(10'h202, 8'h02, "R3 rtc counts");
    rdCheck(10'h207, 8'h18, "R6 interval stopped");

    // R7 cycle counter and its alarm
    wrReg(10'h21A, 8'h03);
    wrReg(10'h200, 8'h20);
    pulses(3);
    snap();
    rdCheck(10'h20C, 8'h03, "R7 cycle count");
    check("R9 irq cycle alarm", {7'b0, alarmIrq}, 8'h01);
    rdCheck(10'h200, 8'h24, "R8 cycle flag");

    // R10 write protect
    wrReg(10'h201, 8'h11);
    wrReg(10'h202, 8'h55);
    snap();
    rdCheck(10'h202, 8'h02, "R10 rtc protected");
    wrReg(10'h210, 8'h77);
    rdCheck(10'h210, 8'h77, "R10 alarm still writable");
    wrReg(10'h201, 8'h41);
    wrReg(10'h20C, 8'h99);
    snap();
    rdCheck(10'h20C, 8'h03, "R10 cycle protected");
    wrReg(10'h201, 8'h01);
    wrReg(10'h20C, 8'h09);
    snap();
    rdCheck(10'h20C, 8'h09, "R10 cycle unprotected");

    // R12 status flags not writable
    wrReg(10'h200, 8'hFF);
    rdCheck(10'h200, 8'h38, "R12 status write");
    check("R12 irq", {7'b0, alarmIrq}, 8'h00);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rdCheck(10'h200, 8'h00, "R1 status after reset");
    rdCheck(10'h201, 8'h00, "R1 control after reset");
    rdCheck(10'h210, 8'h00, "R1 alarm after reset");
    rdCheck(10'h20C, 8'h00, "R1 hold after reset");
    check("R1 irq after reset", {7'b0, alarmIrq}, 8'h00);

    finishRun();
  end
endmodule